// File: doc/BRIEF.md
# Reorder Buffer with Incremental Squash

This block keeps in-flight instructions in program order inside a circular buffer. Dispatch writes a new record (program counter, next program counter, sequence number) at the tail, execution reports completion by slot index, and commit retires the oldest record once it is allowed to leave. The free-entry count and the fields of the oldest and youngest records are driven straight to the ports.

Recovery from a misprediction is spread over time. A squash request carries the sequence number of the last instruction to keep. The buffer then walks from the youngest record toward the oldest, marking at most `SQ_W` records per cycle as squashed and, at the same time, as allowed to commit. Marked records are not deleted. They leave through the ordinary retire path, and the consumer discards them by looking at the squashed flag. Dispatch and retire are held while the walk runs.

Top module: `rob_squash`

## Requirements
- R1: After reset the free count equals `DEPTH`. Head-ready, both error outputs and all head and tail field outputs are 0, and `sq_done_o` is 1.
- R2: An accepted insert stores the record and decrements the free count. The tail fields show the new record on the next cycle, and the first insert into an empty buffer also becomes the head record.
- R3: An insert while the buffer is full raises `ins_err_o` in the same cycle and is ignored: the free count and the tail fields do not change.
- R4: A retire request takes effect only while `head_ready_o` is 1 (`ret_fire_o` shows acceptance). It advances the head to the next older-to-younger record and increments the free count. A request while the head is not ready changes nothing.
- R5: `free_o` always equals `DEPTH` minus the occupancy. An accepted insert and an accepted retire in the same cycle leave it unchanged.
- R6: While the buffer is empty, `head_ready_o` is 0 and every head and tail field output reads 0.
- R7: An accepted squash request drives `sq_done_o` to 0 on the next cycle. A squash request while the buffer is empty or a walk is already running raises `sq_err_o` in the same cycle and is ignored.
- R8: Each walk cycle marks up to `SQ_W` records, starting at the tail and moving toward the head. Each marked record reads back with both squashed and ready-to-commit set. A walk over N younger records takes max(1, ceil(N/`SQ_W`)) cycles, after which `sq_done_o` returns to 1.
- R9: The walk stops at the record whose sequence number equals the requested one. That record is not marked and still needs a completion before it can retire.
- R10: If no record matches, the walk marks the head record and ends.
- R11: While a walk runs, inserts raise `ins_err_o` and are ignored, and retire requests are not accepted.
- R12: A completion for a valid slot index sets the completed and ready-to-commit flags of that record (`head_done_o` shows the completed flag at the head). `head_npc_o` shows the head's next program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert request |
| ins_pc_i | input | PC_W | Program counter of the new record |
| ins_npc_i | input | PC_W | Next program counter of the new record |
| ins_seq_i | input | SEQ_W | Sequence number of the new record |
| ins_err_o | output | 1 | Insert refused (full or walk running) |
| cpl_valid_i | input | 1 | Completion strobe |
| cpl_idx_i | input | IDX_W | Slot index being completed |
| ret_i | input | 1 | Retire request for the head |
| ret_fire_o | output | 1 | Retire accepted this cycle |
| sq_valid_i | input | 1 | Squash request |
| sq_seq_i | input | SEQ_W | Sequence number of the last record to keep |
| sq_err_o | output | 1 | Squash refused (empty or walk running) |
| sq_done_o | output | 1 | No squash walk in progress |
| free_o | output | CNT_W | Number of free entries |
| head_ready_o | output | 1 | Head may retire |
| head_done_o | output | 1 | Head completed flag |
| head_squashed_o | output | 1 | Head squashed flag |
| head_pc_o | output | PC_W | Head program counter |
| head_npc_o | output | PC_W | Head next program counter |
| head_seq_o | output | SEQ_W | Head sequence number |
| tail_pc_o | output | PC_W | Tail program counter |
| tail_seq_o | output | SEQ_W | Tail sequence number |

## Verification
The hardest case to reach is a multi-cycle walk that runs over the wrap point, with a refused insert and a second squash arriving in the middle of it. The bench first fills the buffer, then retires one record while inserting another in the same cycle, which puts the tail on slot 0 and the records to be squashed on the highest slots. It then issues a squash whose target lies four records back. While the walk runs, it drives an insert and a second squash together, and checks that both are refused and that the tail does not move. Draining the buffer afterwards shows at the ports which records were marked and confirms that the matching record was left alone.

// File: rtl/rob_pkg.sv
package rob_pkg;
  parameter int PC_W  = 32;
  parameter int SEQ_W = 16;

  typedef struct packed {
    logic [PC_W-1:0]  pc;
    logic [PC_W-1:0]  npc;
    logic [SEQ_W-1:0] seq;
  } rob_rec_t;
endpackage

// File: rtl/rob_occupancy.sv
module rob_occupancy #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_ok_i,
  input  logic             ret_ok_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  // empty buffer: new record lands on the head slot, tail not advanced
  assign wr_idx_o = (cnt_o == '0) ? head_o : tail_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o <= '0;
      tail_o <= '0;
      cnt_o  <= '0;
    end else begin
      if (ins_ok_i) tail_o <= wr_idx_o;
      if (ret_ok_i) head_o <= head_o + 1'b1;
      case ({ins_ok_i, ret_ok_i})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == DEPTH_C) |-> !ins_ok_i);

  assert_pair_keeps_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_ok_i && ret_ok_i) |=> $stable(cnt_o));

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0) |-> !ret_ok_i);
endmodule

// File: rtl/rob_walker.sv
module rob_walker #(
  parameter int DEPTH = 8,
  parameter int SQ_W  = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SEQ_W = rob_pkg::SEQ_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [SEQ_W-1:0]            tgt_i,
  input  logic [IDX_W-1:0]            head_i,
  input  logic [IDX_W-1:0]            tail_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
  output logic                        busy_o,
  output logic [DEPTH-1:0]            mark_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [SEQ_W-1:0] tgt_q;
  logic             fin;
  logic             act;

  always_comb begin
    ptr_d  = ptr_q;
    act    = busy_o;
    fin    = 1'b0;
    mark_o = '0;
    for (int k = 0; k < SQ_W; k++) begin
      if (act) begin
        if (seq_i[ptr_d] == tgt_q) begin
          act = 1'b0;
          fin = 1'b1;
        end else begin
          mark_o[ptr_d] = 1'b1;
          if (ptr_d == head_i) begin
            act = 1'b0;
            fin = 1'b1;
          end else begin
            ptr_d = ptr_d - 1'b1;
          end
        end
      end
    end
    // a match right after the last mark ends the walk without a spare cycle
    if (act && seq_i[ptr_d] == tgt_q) fin = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      ptr_q  <= '0;
      tgt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      ptr_q  <= tail_i;
      tgt_q  <= tgt_i;
    end else if (busy_o) begin
      ptr_q <= ptr_d;
      if (fin) busy_o <= 1'b0;
    end
  end

  assert_tail_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(tail_i));

  assert_head_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(head_i));

  assert_mark_budget_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mark_o) <= SQ_W);
endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SEQ_W = rob_pkg::SEQ_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  rob_pkg::rob_rec_t           wr_rec_i,
  input  logic                        cpl_i,
  input  logic [IDX_W-1:0]            cpl_idx_i,
  input  logic                        clr_i,
  input  logic [IDX_W-1:0]            clr_idx_i,
  input  logic [DEPTH-1:0]            mark_i,
  output rob_pkg::rob_rec_t [DEPTH-1:0] rec_o,
  output logic [DEPTH-1:0][SEQ_W-1:0] seq_o,
  output logic [DEPTH-1:0]            done_o,
  output logic [DEPTH-1:0]            can_cmt_o,
  output logic [DEPTH-1:0]            squashed_o
);
  logic [DEPTH-1:0] valid_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign seq_o[g] = rec_o[g].seq;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rec_o[g]      <= '0;
        valid_q[g]    <= 1'b0;
        done_o[g]     <= 1'b0;
        can_cmt_o[g]  <= 1'b0;
        squashed_o[g] <= 1'b0;
      end else if (we_i && wr_idx_i == IDX_W'(g)) begin
        rec_o[g]      <= wr_rec_i;
        valid_q[g]    <= 1'b1;
        done_o[g]     <= 1'b0;
        can_cmt_o[g]  <= 1'b0;
        squashed_o[g] <= 1'b0;
      end else begin
        if (clr_i && clr_idx_i == IDX_W'(g)) valid_q[g] <= 1'b0;
        if (cpl_i && cpl_idx_i == IDX_W'(g) && valid_q[g]) begin
          done_o[g]    <= 1'b1;
          can_cmt_o[g] <= 1'b1;
        end
        if (mark_i[g]) begin
          squashed_o[g] <= 1'b1;
          can_cmt_o[g]  <= 1'b1;
        end
      end
    end
  end

  assert_mark_live_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_i & ~valid_q) == '0);

  assert_write_free_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !valid_q[wr_idx_i]);
endmodule

// File: rtl/rob_squash.sv
module rob_squash #(
  parameter int DEPTH = 8,
  parameter int SQ_W  = 2,
  localparam int PC_W  = rob_pkg::PC_W,
  localparam int SEQ_W = rob_pkg::SEQ_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_valid_i,
  input  logic [PC_W-1:0]  ins_pc_i,
  input  logic [PC_W-1:0]  ins_npc_i,
  input  logic [SEQ_W-1:0] ins_seq_i,
  output logic             ins_err_o,
  input  logic             cpl_valid_i,
  input  logic [IDX_W-1:0] cpl_idx_i,
  input  logic             ret_i,
  output logic             ret_fire_o,
  input  logic             sq_valid_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  output logic             sq_err_o,
  output logic             sq_done_o,
  output logic [CNT_W-1:0] free_o,
  output logic             head_ready_o,
  output logic             head_done_o,
  output logic             head_squashed_o,
  output logic [PC_W-1:0]  head_pc_o,
  output logic [PC_W-1:0]  head_npc_o,
  output logic [SEQ_W-1:0] head_seq_o,
  output logic [PC_W-1:0]  tail_pc_o,
  output logic [SEQ_W-1:0] tail_seq_o
);
  import rob_pkg::*;

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [IDX_W-1:0] head, tail, wr_idx;
  logic [CNT_W-1:0] cnt;
  logic             empty, full, busy;
  logic             ins_ok, ret_ok, sq_ok;
  logic [DEPTH-1:0] mark, done_v, cmt_v, sq_v;
  rob_rec_t [DEPTH-1:0]          recs;
  logic [DEPTH-1:0][SEQ_W-1:0]   seqs;
  rob_rec_t         wr_rec;

  assign empty  = (cnt == '0);
  assign full   = (cnt == DEPTH_C);
  assign ins_ok = ins_valid_i && !full && !busy;
  assign ret_ok = ret_i && head_ready_o && !busy;
  assign sq_ok  = sq_valid_i && !empty && !busy;

  assign ins_err_o  = ins_valid_i && (full || busy);
  assign sq_err_o   = sq_valid_i && (empty || busy);
  assign ret_fire_o = ret_ok;
  assign sq_done_o  = !busy;
  assign free_o     = DEPTH_C - cnt;

  assign wr_rec = '{pc: ins_pc_i, npc: ins_npc_i, seq: ins_seq_i};

  rob_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk_i, .rst_ni,
    .ins_ok_i (ins_ok),
    .ret_ok_i (ret_ok),
    .head_o   (head),
    .tail_o   (tail),
    .wr_idx_o (wr_idx),
    .cnt_o    (cnt)
  );

  rob_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .we_i       (ins_ok),
    .wr_idx_i   (wr_idx),
    .wr_rec_i   (wr_rec),
    .cpl_i      (cpl_valid_i),
    .cpl_idx_i  (cpl_idx_i),
    .clr_i      (ret_ok),
    .clr_idx_i  (head),
    .mark_i     (mark),
    .rec_o      (recs),
    .seq_o      (seqs),
    .done_o     (done_v),
    .can_cmt_o  (cmt_v),
    .squashed_o (sq_v)
  );

  rob_walker #(.DEPTH(DEPTH), .SQ_W(SQ_W)) u_walk (
    .clk_i, .rst_ni,
    .start_i (sq_ok),
    .tgt_i   (sq_seq_i),
    .head_i  (head),
    .tail_i  (tail),
    .seq_i   (seqs),
    .busy_o  (busy),
    .mark_o  (mark)
  );

  always_comb begin
    head_ready_o    = 1'b0;
    head_done_o     = 1'b0;
    head_squashed_o = 1'b0;
    head_pc_o       = '0;
    head_npc_o      = '0;
    head_seq_o      = '0;
    tail_pc_o       = '0;
    tail_seq_o      = '0;
    if (!empty) begin
      head_ready_o    = cmt_v[head];
      head_done_o     = done_v[head];
      head_squashed_o = sq_v[head];
      head_pc_o       = recs[head].pc;
      head_npc_o      = recs[head].npc;
      head_seq_o      = recs[head].seq;
      tail_pc_o       = recs[tail].pc;
      tail_seq_o      = recs[tail].seq;
    end
  end

  initial assert_pow2_depth_R5: assert ((DEPTH & (DEPTH - 1)) == 0 && DEPTH > 1);

  assert_empty_not_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_o == DEPTH_C) |-> !head_ready_o);

  assert_done_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_ok |=> !sq_done_o);

  assert_no_retire_in_walk_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sq_done_o |-> !ret_fire_o);
endmodule

// File: tb/rob_squash_tb.sv
module rob_squash_tb;
  localparam int DEPTH = 8;
  localparam int SQ_W  = 2;
  localparam int IDX_W = 3;
  localparam int CNT_W = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ins_valid_i = 1'b0;
  logic [31:0] ins_pc_i = '0, ins_npc_i = '0;
  logic [15:0] ins_seq_i = '0;
  logic        ins_err_o;
  logic        cpl_valid_i = 1'b0;
  logic [IDX_W-1:0] cpl_idx_i = '0;
  logic        ret_i = 1'b0, ret_fire_o;
  logic        sq_valid_i = 1'b0;
  logic [15:0] sq_seq_i = '0;
  logic        sq_err_o, sq_done_o;
  logic [CNT_W-1:0] free_o;
  logic        head_ready_o, head_done_o, head_squashed_o;
  logic [31:0] head_pc_o, head_npc_o, tail_pc_o;
  logic [15:0] head_seq_o, tail_seq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  rob_squash #(.DEPTH(DEPTH), .SQ_W(SQ_W)) u_dut (.*);

  // {pc, seq, expected free after insert}
  localparam logic [55:0] VEC [8] = '{
    {32'h100, 16'd10, 8'd7}, {32'h104, 16'd11, 8'd6},
    {32'h108, 16'd12, 8'd5}, {32'h10c, 16'd13, 8'd4},
    {32'h110, 16'd14, 8'd3}, {32'h114, 16'd15, 8'd2},
    {32'h118, 16'd16, 8'd1}, {32'h11c, 16'd17, 8'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    #2;
  endtask

  task automatic idle;
    ins_valid_i = 1'b0; cpl_valid_i = 1'b0; ret_i = 1'b0; sq_valid_i = 1'b0;
  endtask

  task automatic ins(input logic [31:0] pc, input logic [15:0] seq);
    ins_valid_i = 1'b1; ins_pc_i = pc; ins_npc_i = pc + 32'd4; ins_seq_i = seq;
  endtask

  task automatic complete(input int idx);
    cpl_valid_i = 1'b1; cpl_idx_i = IDX_W'(idx);
    tick; idle;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    summary;
    $finish;
  end

  initial begin
    #35 rst_ni = 1'b1;
    tick;
    // R1 reset state
    chk("R1 free", 32'(free_o), DEPTH);
    chk("R1 head_ready", 32'(head_ready_o), 0);
    chk("R1 sq_done", 32'(sq_done_o), 1);
    chk("R1 tail_seq", 32'(tail_seq_o), 0);
    chk("R1 errs", 32'({ins_err_o, sq_err_o}), 0);

    // R2/R5 fill from table
    for (int i = 0; i < 8; i++) begin
      ins(VEC[i][55:24], VEC[i][23:8]);
      tick; idle;
      chk("R2 free", 32'(free_o), 32'(VEC[i][7:0]));
      chk("R2 tail_seq", 32'(tail_seq_o), 32'(VEC[i][23:8]));
      chk("R2 head_seq", 32'(head_seq_o), 10);
    end
    chk("R2 tail_pc", tail_pc_o, 32'h11c);

    // R3 insert when full
    ins(32'h900, 16'd99); #1;
    chk("R3 ins_err", 32'(ins_err_o), 1);
    tick; idle;
    chk("R3 free", 32'(free_o), 0);
    chk("R3 tail_seq", 32'(tail_seq_o), 17);

    // R4 retire of a not-ready head is ignored
    ret_i = 1'b1; #1;
    chk("R4 no fire", 32'(ret_fire_o), 0);
    tick; idle;
    chk("R4 free", 32'(free_o), 0);
    chk("R4 head_seq", 32'(head_seq_o), 10);

    // R12 completion makes head ready
    complete(0);
    chk("R12 ready", 32'(head_ready_o), 1);
    chk("R12 done", 32'(head_done_o), 1);
    chk("R12 npc", head_npc_o, 32'h104);
    ret_i = 1'b1; #1;
    chk("R4 fire", 32'(ret_fire_o), 1);
    tick; idle;
    chk("R4 free after", 32'(free_o), 1);
    chk("R4 head_seq after", 32'(head_seq_o), 11);

    // R5 insert and retire together; tail wraps to slot 0
    complete(1);
    ins(32'h120, 16'd18); ret_i = 1'b1;
    tick; idle;
    chk("R5 free", 32'(free_o), 1);
    chk("R5 tail_seq", 32'(tail_seq_o), 18);
    chk("R5 head_seq", 32'(head_seq_o), 12);

    // R7/R8/R11 squash keeping seq 14: four younger records, two walk cycles
    sq_valid_i = 1'b1; sq_seq_i = 16'd14;
    tick; idle;
    chk("R7 done low", 32'(sq_done_o), 0);
    ins(32'h200, 16'd50); sq_valid_i = 1'b1; sq_seq_i = 16'd11; ret_i = 1'b1; #1;
    chk("R11 ins_err", 32'(ins_err_o), 1);
    chk("R11 no retire", 32'(ret_fire_o), 0);
    chk("R7 busy sq_err", 32'(sq_err_o), 1);
    tick; idle;
    chk("R8 still walking", 32'(sq_done_o), 0);
    chk("R11 tail_seq", 32'(tail_seq_o), 18);
    chk("R11 free", 32'(free_o), 1);
    tick;
    chk("R8 walk done", 32'(sq_done_o), 1);

    // drain: 12, 13 normal
    complete(2); complete(3);
    for (int i = 0; i < 2; i++) begin
      chk("R8 kept unsquashed", 32'(head_squashed_o), 0);
      ret_i = 1'b1; tick; idle;
    end
    // R9 matching record left unmarked
    chk("R9 match seq", 32'(head_seq_o), 14);
    chk("R9 not ready", 32'(head_ready_o), 0);
    chk("R9 not squashed", 32'(head_squashed_o), 0);
    complete(4);
    ret_i = 1'b1; tick; idle;
    // R8 marked records 15..18 drain as squashed and ready
    for (int i = 0; i < 4; i++) begin
      chk("R8 seq", 32'(head_seq_o), 15 + i);
      chk("R8 squashed", 32'(head_squashed_o), 1);
      chk("R8 ready", 32'(head_ready_o), 1);
      ret_i = 1'b1; tick; idle;
    end

    // R6 empty
    chk("R6 free", 32'(free_o), DEPTH);
    chk("R6 head_ready", 32'(head_ready_o), 0);
    chk("R6 fields", 32'({head_seq_o, tail_seq_o}), 0);
    chk("R6 head_pc", head_pc_o, 0);

    // R7 squash on empty
    sq_valid_i = 1'b1; sq_seq_i = 16'd3; #1;
    chk("R7 empty sq_err", 32'(sq_err_o), 1);
    tick; idle;
    chk("R7 empty ignored", 32'(sq_done_o), 1);

    // R10 no match: walk reaches head
    for (int i = 0; i < 3; i++) begin
      ins(32'h300 + 32'(4 * i), 16'(30 + i)); tick; idle;
    end
    chk("R2 head after empty", 32'(head_seq_o), 30);
    sq_valid_i = 1'b1; sq_seq_i = 16'd5;
    tick; idle;
    tick;
    chk("R10 mid walk", 32'(sq_done_o), 0);
    tick;
    chk("R10 done", 32'(sq_done_o), 1);
    chk("R10 head squashed", 32'(head_squashed_o), 1);
    chk("R10 head ready", 32'(head_ready_o), 1);

    summary;
    $finish;
  end
endmodule